// File: doc/BRIEF.md
# Card Host Interrupt Request and DMA Steering

This block gathers the event flags of a memory-card host controller into a request register of thirteen sources, filters them through a mask register and produces one combined interrupt line for the processor. Datapath logic raises a source with a set strobe and lowers it with a clear strobe. Software loads the mask, and a mask bit of 1 silences that source.

Two of the sources ask for FIFO service: source 5 for receive and source 6 for transmit. A DMA-enable level from the command control word moves these two sources away from the processor. While it is high, they drive their own DMA request lines and can no longer raise the processor interrupt. While it is low, both DMA lines stay low and the two sources behave like any other source. Both registers can be read back. Every output is registered and follows its inputs one clock later.

Top module: `mci_irq_steer`

## Requirements
- R1: Reset clears the request and mask registers and drives the interrupt line and both DMA lines low.
- R2: A set strobe on source b makes request bit b read as 1 one cycle later, and the bit stays 1 until a clear strobe reaches it.
- R3: A clear strobe on source b, with no set strobe on b in the same cycle, makes request bit b read as 0 one cycle later.
- R4: When a set strobe and a clear strobe reach the same source in the same cycle, the bit becomes 1.
- R5: A mask write takes bits 12:0 of the 16-bit write data. Write-data bits 15:13 are discarded and read back as nothing.
- R6: One cycle after any change, the interrupt line is 1 exactly when a request bit is 1 whose mask bit is 0. With DMA disabled this applies to all sources.
- R7: While DMA is enabled, request bits 5 (receive service) and 6 (transmit service) never raise the interrupt line, whatever the mask holds.
- R8: While DMA is enabled, the receive DMA line equals request bit 5 and the transmit DMA line equals request bit 6. The mask has no effect on these lines. The lines update one cycle after a change.
- R9: While DMA is disabled, both DMA lines are 0.
- R10: The request and mask registers are presented on read-back outputs with bit b holding source b.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| set_i | input | 13 | Per-source set strobes |
| clr_i | input | 13 | Per-source clear strobes |
| mask_we_i | input | 1 | Mask write enable |
| mask_wdata_i | input | 16 | Mask write data; bits 12:0 are kept |
| dma_en_i | input | 1 | DMA-enable level for FIFO service sources |
| req_o | output | 13 | Request register read-back |
| mask_o | output | 13 | Mask register read-back |
| cpu_irq_o | output | 1 | Combined processor interrupt |
| rx_dma_o | output | 1 | Receive DMA request |
| tx_dma_o | output | 1 | Transmit DMA request |

## Verification
A single-source walk sets each of the thirteen sources in turn. For each one the bench checks that the interrupt follows the source, that the source's own mask bit silences it, that stray write-data bits above bit 12 are dropped, and that the clear strobe removes it, so a wrong bit position or a wrong polarity shows up. A step with every set and clear strobe active at once separates set-wins from clear-wins. A directed DMA sequence drives the two FIFO sources with DMA enabled and disabled and with their mask bits set, so the DMA lines can be told apart from the mask and from the interrupt path. A long pseudo-random sweep then mixes strobes, mask writes and DMA toggling, and compares every output against an arithmetic model cycle by cycle.

// File: rtl/mci_irq_pkg.sv
package mci_irq_pkg;
   localparam int unsigned SRC_COUNT   = 13;
   localparam int unsigned SRC_RX_SVC  = 5;
   localparam int unsigned SRC_TX_SVC  = 6;
   localparam int unsigned WDATA_WIDTH = 16;
endpackage

// File: rtl/mci_req_bank.sv
module mci_req_bank #(
   parameter int unsigned N = 13
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] set_i,
   input  logic [N-1:0] clr_i,
   output logic [N-1:0] req_d_o,
   output logic [N-1:0] req_q_o
);
   if (N < 1) begin : g_bad_n
      $error("mci_req_bank: N must be positive");
   end

   for (genvar b = 0; b < N; b++) begin : g_bit
      logic nxt;
      logic cur;
      always_comb nxt = set_i[b] | (cur & ~clr_i[b]);
      always_ff @(posedge clk) begin
         if (!rst_n) cur <= 1'b0;
         else        cur <= nxt;
      end
      assign req_d_o[b] = nxt;
      assign req_q_o[b] = cur;

      p_set_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
         set_i[b] |=> req_q_o[b]);
      p_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
         (clr_i[b] && !set_i[b]) |=> !req_q_o[b]);
      p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
         (!clr_i[b] && !set_i[b]) |=> (req_q_o[b] == $past(req_q_o[b])));
   end
endmodule

// File: rtl/mci_mask_reg.sv
module mci_mask_reg #(
   parameter int unsigned N  = 13,
   parameter int unsigned WD = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we_i,
   input  logic [WD-1:0] wdata_i,
   output logic [N-1:0]  mask_d_o,
   output logic [N-1:0]  mask_q_o
);
   if (WD < N) begin : g_bad_wd
      $error("mci_mask_reg: write data narrower than mask");
   end

   logic [N-1:0] mask_q;
   always_comb mask_d_o = we_i ? wdata_i[N-1:0] : mask_q;
   always_ff @(posedge clk) begin
      if (!rst_n) mask_q <= '0;
      else        mask_q <= mask_d_o;
   end
   assign mask_q_o = mask_q;

   p_mask_trunc_r5: assert property (@(posedge clk) disable iff (!rst_n)
      we_i |=> (mask_q_o == $past(wdata_i[N-1:0])));
   p_mask_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !we_i |=> $stable(mask_q_o));
endmodule

// File: rtl/mci_steer.sv
module mci_steer #(
   parameter int unsigned N     = 13,
   parameter int unsigned RX    = 5,
   parameter int unsigned TX    = 6
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] req_d_i,
   input  logic [N-1:0] mask_d_i,
   input  logic         dma_en_i,
   output logic         irq_o,
   output logic         rx_dma_o,
   output logic         tx_dma_o
);
   if (RX >= N || TX >= N || RX == TX) begin : g_bad_idx
      $error("mci_steer: FIFO service positions out of range");
   end

   logic [N-1:0] svc_vec;
   for (genvar b = 0; b < N; b++) begin : g_svc
      if (b == RX || b == TX) begin : g_on
         assign svc_vec[b] = 1'b1;
      end else begin : g_off
         assign svc_vec[b] = 1'b0;
      end
   end

   logic [N-1:0] eff_mask;
   logic         irq_d, rx_d, tx_d;
   always_comb begin
      eff_mask = mask_d_i | (dma_en_i ? svc_vec : '0);
      irq_d    = |(req_d_i & ~eff_mask);
      rx_d     = dma_en_i & req_d_i[RX];
      tx_d     = dma_en_i & req_d_i[TX];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         irq_o    <= 1'b0;
         rx_dma_o <= 1'b0;
         tx_dma_o <= 1'b0;
      end else begin
         irq_o    <= irq_d;
         rx_dma_o <= rx_d;
         tx_dma_o <= tx_d;
      end
   end

   p_dma_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !dma_en_i |=> (!rx_dma_o && !tx_dma_o));
endmodule

// File: rtl/mci_irq_steer.sv
module mci_irq_steer
   import mci_irq_pkg::*;
#(
   parameter int unsigned N  = SRC_COUNT,
   parameter int unsigned RX = SRC_RX_SVC,
   parameter int unsigned TX = SRC_TX_SVC,
   parameter int unsigned WD = WDATA_WIDTH
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [N-1:0]  set_i,
   input  logic [N-1:0]  clr_i,
   input  logic          mask_we_i,
   input  logic [WD-1:0] mask_wdata_i,
   input  logic          dma_en_i,
   output logic [N-1:0]  req_o,
   output logic [N-1:0]  mask_o,
   output logic          cpu_irq_o,
   output logic          rx_dma_o,
   output logic          tx_dma_o
);
   localparam logic [N-1:0] SVC_BITS = (N'(1) << RX) | (N'(1) << TX);

   logic [N-1:0] req_d, mask_d;

   mci_req_bank #(.N(N)) u_bank (
      .clk(clk), .rst_n(rst_n), .set_i(set_i), .clr_i(clr_i),
      .req_d_o(req_d), .req_q_o(req_o)
   );

   mci_mask_reg #(.N(N), .WD(WD)) u_mask (
      .clk(clk), .rst_n(rst_n), .we_i(mask_we_i), .wdata_i(mask_wdata_i),
      .mask_d_o(mask_d), .mask_q_o(mask_o)
   );

   mci_steer #(.N(N), .RX(RX), .TX(TX)) u_steer (
      .clk(clk), .rst_n(rst_n), .req_d_i(req_d), .mask_d_i(mask_d),
      .dma_en_i(dma_en_i), .irq_o(cpu_irq_o), .rx_dma_o(rx_dma_o),
      .tx_dma_o(tx_dma_o)
   );

   p_irq_plain_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !dma_en_i |=> (cpu_irq_o == |(req_o & ~mask_o)));
   p_irq_dma_r7: assert property (@(posedge clk) disable iff (!rst_n)
      dma_en_i |=> (cpu_irq_o == |(req_o & ~mask_o & ~SVC_BITS)));
   p_rx_follow_r8: assert property (@(posedge clk) disable iff (!rst_n)
      dma_en_i |=> (rx_dma_o == req_o[RX] && tx_dma_o == req_o[TX]));
endmodule

// File: tb/tb_mci_irq_steer.sv
`timescale 1ns/1ps
module tb_mci_irq_steer;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [12:0] set_i = '0, clr_i = '0;
   logic        mask_we_i = 1'b0;
   logic [15:0] mask_wdata_i = '0;
   logic        dma_en_i = 1'b0;
   logic [12:0] req_o, mask_o;
   logic        cpu_irq_o, rx_dma_o, tx_dma_o;

   int checks = 0, fails = 0;
   logic [12:0] m_req = '0, m_mask = '0;
   logic        m_dma = 1'b0;

   always #10 clk = ~clk;

   mci_irq_steer dut (
      .clk(clk), .rst_n(rst_n), .set_i(set_i), .clr_i(clr_i),
      .mask_we_i(mask_we_i), .mask_wdata_i(mask_wdata_i), .dma_en_i(dma_en_i),
      .req_o(req_o), .mask_o(mask_o), .cpu_irq_o(cpu_irq_o),
      .rx_dma_o(rx_dma_o), .tx_dma_o(tx_dma_o)
   );

   task automatic chk(input string tag, input logic [12:0] act, input logic [12:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic chk_all(input string tag);
      logic [12:0] em;
      em = m_mask | (m_dma ? 13'h0060 : 13'h0);
      chk({tag, " R10 req"}, req_o, m_req);
      chk({tag, " R5 mask"}, mask_o, m_mask);
      chk({tag, " R6/R7 irq"}, 13'(cpu_irq_o), 13'(|(m_req & ~em)));
      chk({tag, " R8/R9 rx"}, 13'(rx_dma_o), 13'(m_dma & m_req[5]));
      chk({tag, " R8/R9 tx"}, 13'(tx_dma_o), 13'(m_dma & m_req[6]));
   endtask

   // drive at negedge, one posedge, sample at following negedge
   task automatic cyc(input logic [12:0] s, input logic [12:0] c,
                      input logic we, input logic [15:0] wd, input logic dma);
      set_i = s; clr_i = c; mask_we_i = we; mask_wdata_i = wd; dma_en_i = dma;
      m_req = (m_req & ~c) | s;
      if (we) m_mask = wd[12:0];
      m_dma = dma;
      @(negedge clk);
      set_i = '0; clr_i = '0; mask_we_i = 1'b0;
   endtask

   initial begin
      #(20 * 5000);
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      logic [15:0] lfsr;
      repeat (3) @(negedge clk);
      // R1 reset state
      chk("R1 req", req_o, '0);
      chk("R1 mask", mask_o, '0);
      chk("R1 outs", {10'b0, cpu_irq_o, rx_dma_o, tx_dma_o}, '0);
      rst_n = 1'b1;
      @(negedge clk);
      chk_all("R1 idle");

      // single-source walk, DMA off
      for (int b = 0; b < 13; b++) begin
         cyc(13'(1) << b, '0, 1'b0, '0, 1'b0);
         chk_all("R2 set walk");
         chk("R6 irq on", 13'(cpu_irq_o), 13'd1);
         cyc('0, '0, 1'b0, '0, 1'b0);
         chk("R2 hold", req_o, 13'(1) << b);
         cyc('0, '0, 1'b1, 16'hE000 | (16'(1) << b), 1'b0);
         chk("R5 trunc", mask_o, 13'(1) << b);
         chk("R6 masked", 13'(cpu_irq_o), 13'd0);
         cyc('0, 13'(1) << b, 1'b1, 16'h0000, 1'b0);
         chk("R3 clear", req_o, '0);
         chk_all("R3 walk");
      end

      // R4 set wins over clear
      cyc(13'h1FFF, 13'h1FFF, 1'b0, '0, 1'b0);
      chk("R4 set wins", req_o, 13'h1FFF);
      cyc('0, 13'h1FFF, 1'b0, '0, 1'b0);
      chk("R3 clear all", req_o, '0);

      // DMA steering
      cyc(13'h0020, '0, 1'b0, '0, 1'b1);
      chk("R7 rx no irq", 13'(cpu_irq_o), 13'd0);
      chk("R8 rx dma", 13'(rx_dma_o), 13'd1);
      chk("R8 tx idle", 13'(tx_dma_o), 13'd0);
      cyc(13'h0040, '0, 1'b1, 16'h0060, 1'b1);
      chk("R8 tx dma masked", 13'(tx_dma_o), 13'd1);
      chk("R8 rx dma masked", 13'(rx_dma_o), 13'd1);
      cyc(13'h0001, '0, 1'b1, 16'h0000, 1'b1);
      chk("R7 other src irq", 13'(cpu_irq_o), 13'd1);
      cyc('0, 13'h0001, 1'b0, '0, 1'b0);
      chk("R9 rx off", 13'(rx_dma_o), 13'd0);
      chk("R9 tx off", 13'(tx_dma_o), 13'd0);
      chk("R6 svc to cpu", 13'(cpu_irq_o), 13'd1);
      chk_all("R9 dma off");
      cyc('0, 13'h1FFF, 1'b0, '0, 1'b0);

      // pseudo-random sweep against arithmetic model
      lfsr = 16'hACE1;
      for (int i = 0; i < 400; i++) begin
         logic [12:0] s, c;
         logic we, dm;
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         s  = 13'(lfsr) & 13'(lfsr >> 3) & 13'(lfsr >> 5);
         c  = 13'(~lfsr) & 13'(lfsr >> 2);
         we = lfsr[1] & lfsr[4];
         dm = lfsr[7];
         cyc(s, c, we, {lfsr[2:0], lfsr[15:3]}, dm);
         chk_all("R2/R3/R4/R6/R7/R8 sweep");
      end

      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule